// File: doc/BRIEF.md
# Write-Allocate Decision Unit

This block decides whether a write that missed the L1 data cache should bring its line into the cache. A requester pulses a strobe with the write address and the conditions that apply to it: three global or per-page cache-off controls, the memory type of the target region, and the result of the sector tag lookup done elsewhere. One cycle later the block returns a registered allocate or no-allocate verdict together with a reason code.

The decision follows a fixed priority. Any hard blocker (cache disabled, page caching disabled, cache inhibited, or an uncacheable or write-combining region) forbids allocation. If none applies, a write to the page of the most recent read-miss fill, or a write into a valid sector whose addressed line is empty, is allocated. Failing both, a programmable limit path allocates writes below a limit given in 4 MB units, except in the legacy video and ROM hole just under 1 MB. The block keeps one internal register, the page address of the last read-miss fill, which it loads when a fill completes.

Top module: `wralloc_decider`

## Requirements
- R1: While `cache_dis` is 1 at the strobe, the verdict is no-allocate with reason BLOCKED (code 1).
- R2: While `page_cd` is 1 at the strobe, the verdict is no-allocate with reason BLOCKED (code 1).
- R3: While `cache_inh` is 1 at the strobe, the verdict is no-allocate with reason BLOCKED (code 1).
- R4: A write with `mem_uc` or `mem_wc` set is never allocated; reason BLOCKED (code 1).
- R5: The stored page is bits [31:12] of a fill address and has a valid flag. A non-blocked write whose bits [31:12] equal a valid stored page is allocated with reason PAGE_HIT (code 2).
- R6: A non-blocked write with `sec_tag_hit` 1 and `sec_line_valid` 0 that is not a page hit is allocated with reason SECTOR_HIT (code 3).
- R7: When no blocker, page hit or sector hit applies, a write with `limit_field` nonzero and address bits [31:22] less than `limit_field` is allocated with reason BELOW_LIMIT (code 4); a limit of 0 never allocates on this path.
- R8: Addresses 0x000A_0000 to 0x000F_FFFF inclusive are never allocated by the limit path; such a write without page or sector hit gets no-allocate with reason NONE (code 0).
- R9: Page hit and sector hit override the limit and hole rules but not the blockers; when both hit, PAGE_HIT is reported.
- R10: `dec_valid` is 1 exactly in the cycle after a cycle with `wr_req` 1; in other cycles `dec_alloc` is 0 and `dec_reason` is NONE (code 0).
- R11: When `fill_done` is 1 with `cache_dis` and `cache_inh` both 0, the stored page takes `fill_page` and becomes valid at that clock edge; otherwise it is unchanged. A write strobed in the same cycle is judged against the old stored page.
- R12: After reset, `dec_valid` and `dec_alloc` are 0 and the stored page is invalid, so no write can be a page hit before the first fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write-miss decision strobe |
| wr_addr | input | 32 | Address of the pending write |
| cache_dis | input | 1 | Global cache-disable control |
| page_cd | input | 1 | Page cache-disable for this write |
| cache_inh | input | 1 | Cache-inhibit test control |
| mem_uc | input | 1 | Target region typed uncacheable |
| mem_wc | input | 1 | Target region typed write-combining |
| sec_tag_hit | input | 1 | Write address matches a valid sector tag |
| sec_line_valid | input | 1 | Addressed line in that sector is valid |
| limit_field | input | 7 | Allocation limit in 4 MB units, 0 disables |
| fill_done | input | 1 | A read-miss line fill completes this cycle |
| fill_page | input | 20 | Page number (address bits 31:12) of that fill |
| dec_valid | output | 1 | Verdict present this cycle |
| dec_alloc | output | 1 | Allocate the line |
| dec_reason | output | 3 | Reason code (0 none, 1 blocked, 2 page hit, 3 sector hit, 4 below limit) |

## Verification
The assertions take the condition inputs as meaningful only in the cycle where `wr_req` is high, and treat `sec_line_valid` as a don't-care when `sec_tag_hit` is low; they check the verdict one cycle after the strobe against the named internal conditions. The stimulus holds every input stable for one full cycle, drives them at the falling edge, and draws addresses from pools that land on the legacy hole, its borders, low memory, recently filled pages and random space, so each priority level is reached. Blockers are drawn with low probability so the override paths stay well exercised.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_BLOCKED = 3'd1,
    RSN_PAGE    = 3'd2,
    RSN_SECTOR  = 3'd3,
    RSN_LIMIT   = 3'd4
  } wa_reason_e;
endpackage

// File: rtl/wa_page_tracker.sv
module wa_page_tracker #(
  parameter int PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [PAGE_W-1:0] load_page,
  input  logic [PAGE_W-1:0] probe_page,
  output logic              page_vld,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_match
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_vld <= 1'b0;
      page_q   <= '0;
    end else if (load_en) begin
      page_vld <= 1'b1;
      page_q   <= load_page;
    end
  end

  assign page_match = page_vld && (page_q == probe_page);
endmodule

// File: rtl/wa_limit_check.sv
module wa_limit_check #(
  parameter int          ADDR_W    = 32,
  parameter int          LIM_W     = 7,
  parameter int          LIM_SHIFT = 22,
  parameter logic [31:0] HOLE_LO   = 32'h000A_0000,
  parameter logic [31:0] HOLE_HI   = 32'h000F_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LIM_W-1:0]  limit,
  output logic              in_hole,
  output logic              limit_ok
);
  localparam int REG_W = ADDR_W - LIM_SHIFT;
  localparam int CMP_W = (LIM_W > REG_W) ? LIM_W : REG_W;

  function automatic logic hole_hit(input logic [ADDR_W-1:0] a);
    return (ADDR_W'(HOLE_LO) <= a) && (a <= ADDR_W'(HOLE_HI));
  endfunction

  function automatic logic below_limit(input logic [ADDR_W-1:0] a,
                                       input logic [LIM_W-1:0]  lim);
    logic [CMP_W-1:0] region;
    logic [CMP_W-1:0] bound;
    region = CMP_W'(a[ADDR_W-1:LIM_SHIFT]);
    bound  = CMP_W'(lim);
    return (lim != '0) && (region < bound);
  endfunction

  assign in_hole  = hole_hit(addr);
  assign limit_ok = below_limit(addr, limit) && !in_hole;
endmodule

// File: rtl/wa_decision.sv
module wa_decision
  import wa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       hard_block,
  input  logic       page_match,
  input  logic       sector_match,
  input  logic       limit_ok,
  output logic       dec_valid,
  output logic       dec_alloc,
  output logic [2:0] dec_reason
);
  wa_reason_e rsn_d;
  logic       alloc_d;

  always_comb begin
    if (hard_block)        rsn_d = RSN_BLOCKED;
    else if (page_match)   rsn_d = RSN_PAGE;
    else if (sector_match) rsn_d = RSN_SECTOR;
    else if (limit_ok)     rsn_d = RSN_LIMIT;
    else                   rsn_d = RSN_NONE;
    alloc_d = (rsn_d == RSN_PAGE) || (rsn_d == RSN_SECTOR) || (rsn_d == RSN_LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_alloc  <= 1'b0;
      dec_reason <= RSN_NONE;
    end else begin
      dec_valid  <= req;
      dec_alloc  <= req && alloc_d;
      dec_reason <= req ? rsn_d : RSN_NONE;
    end
  end
endmodule

// File: rtl/wralloc_decider.sv
module wralloc_decider #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int LIM_W      = 7,
  parameter int LIM_SHIFT  = 22
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_req,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic                         cache_dis,
  input  logic                         page_cd,
  input  logic                         cache_inh,
  input  logic                         mem_uc,
  input  logic                         mem_wc,
  input  logic                         sec_tag_hit,
  input  logic                         sec_line_valid,
  input  logic [LIM_W-1:0]             limit_field,
  input  logic                         fill_done,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] fill_page,
  output logic                         dec_valid,
  output logic                         dec_alloc,
  output logic [2:0]                   dec_reason
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  // Named internal events, observed by the bound checker.
  logic              hard_block;
  logic              page_match;
  logic              sector_match;
  logic              limit_ok;
  logic              in_hole;
  logic              page_vld;
  logic              fill_load;
  logic [PAGE_W-1:0] page_q;

  assign hard_block   = cache_dis || page_cd || cache_inh || mem_uc || mem_wc;
  assign sector_match = sec_tag_hit && !sec_line_valid;
  // Fills are suppressed while the cache is globally disabled or inhibited.
  assign fill_load    = fill_done && !cache_dis && !cache_inh;

  wa_page_tracker #(.PAGE_W(PAGE_W)) u_page (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (fill_load),
    .load_page  (fill_page),
    .probe_page (wr_addr[ADDR_W-1:PAGE_SHIFT]),
    .page_vld   (page_vld),
    .page_q     (page_q),
    .page_match (page_match)
  );

  wa_limit_check #(
    .ADDR_W    (ADDR_W),
    .LIM_W     (LIM_W),
    .LIM_SHIFT (LIM_SHIFT)
  ) u_limit (
    .addr     (wr_addr),
    .limit    (limit_field),
    .in_hole  (in_hole),
    .limit_ok (limit_ok)
  );

  wa_decision u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (wr_req),
    .hard_block   (hard_block),
    .page_match   (page_match),
    .sector_match (sector_match),
    .limit_ok     (limit_ok),
    .dec_valid    (dec_valid),
    .dec_alloc    (dec_alloc),
    .dec_reason   (dec_reason)
  );
endmodule

// File: rtl/wralloc_decider_chk.sv
module wralloc_decider_chk #(
  parameter int PAGE_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              cache_dis,
  input logic              page_cd,
  input logic              cache_inh,
  input logic              mem_uc,
  input logic              mem_wc,
  input logic              fill_done,
  input logic              page_match,
  input logic              sector_match,
  input logic              in_hole,
  input logic              page_vld,
  input logic [PAGE_W-1:0] page_q,
  input logic              dec_valid,
  input logic              dec_alloc,
  input logic [2:0]        dec_reason
);
  // R1 R2 R3 R4: any blocker gives a blocked no-allocate verdict
  p_blockers_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && (cache_dis || page_cd || cache_inh || mem_uc || mem_wc)
    |=> dec_valid && !dec_alloc && dec_reason == 3'd1);

  // R5 R9: page hit without blockers allocates
  p_page_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !(cache_dis || page_cd || cache_inh || mem_uc || mem_wc) && page_match
    |=> dec_alloc && dec_reason == 3'd2);

  // R6: sector hit without blockers or page hit allocates
  p_sector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !(cache_dis || page_cd || cache_inh || mem_uc || mem_wc)
      && !page_match && sector_match
    |=> dec_alloc && dec_reason == 3'd3);

  // R8: hole without override never allocates
  p_hole_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && in_hole && !page_match && !sector_match |=> !dec_alloc);

  // R10: verdict timing
  p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> dec_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> !dec_valid && !dec_alloc && dec_reason == 3'd0);

  // R11: suppressed fills leave the stored page alone
  p_fill_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_done || cache_dis || cache_inh) |=> $stable(page_q) && $stable(page_vld));
  p_fill_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done && !cache_dis && !cache_inh |=> page_vld);

  // R12: an invalid stored page never matches
  p_nomatch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !page_vld |-> !page_match);
endmodule

bind wralloc_decider wralloc_decider_chk #(.PAGE_W(ADDR_W - PAGE_SHIFT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_req       (wr_req),
  .cache_dis    (cache_dis),
  .page_cd      (page_cd),
  .cache_inh    (cache_inh),
  .mem_uc       (mem_uc),
  .mem_wc       (mem_wc),
  .fill_done    (fill_done),
  .page_match   (page_match),
  .sector_match (sector_match),
  .in_hole      (in_hole),
  .page_vld     (page_vld),
  .page_q       (page_q),
  .dec_valid    (dec_valid),
  .dec_alloc    (dec_alloc),
  .dec_reason   (dec_reason)
);

// File: tb/wralloc_decider_bench.sv
`timescale 1ns/1ps
module wralloc_decider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0;
  logic [31:0] wr_addr = '0;
  logic        cache_dis = 1'b0, page_cd = 1'b0, cache_inh = 1'b0;
  logic        mem_uc = 1'b0, mem_wc = 1'b0;
  logic        sec_tag_hit = 1'b0, sec_line_valid = 1'b0;
  logic [6:0]  limit_field = '0;
  logic        fill_done = 1'b0;
  logic [19:0] fill_page = '0;
  logic        dec_valid, dec_alloc;
  logic [2:0]  dec_reason;

  int n_run = 0;
  int n_fail = 0;

  // bench-side copy of the stored page
  logic        m_vld = 1'b0;
  logic [19:0] m_page = '0;

  always #10 clk = ~clk;

  wralloc_decider u_wralloc_decider (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .cache_dis(cache_dis), .page_cd(page_cd), .cache_inh(cache_inh),
    .mem_uc(mem_uc), .mem_wc(mem_wc), .sec_tag_hit(sec_tag_hit),
    .sec_line_valid(sec_line_valid), .limit_field(limit_field),
    .fill_done(fill_done), .fill_page(fill_page),
    .dec_valid(dec_valid), .dec_alloc(dec_alloc), .dec_reason(dec_reason)
  );

  function automatic logic [2:0] exp_reason(input logic [31:0] a);
    int unsigned mb4;
    bit hole;
    if (cache_dis | page_cd | cache_inh | mem_uc | mem_wc) return 3'd1;
    if (m_vld && (a >> 12) == {12'd0, m_page}) return 3'd2;
    if (sec_tag_hit && !sec_line_valid) return 3'd3;
    mb4  = a / 32'h0040_0000;
    hole = (a >= 32'h000A_0000) && (a < 32'h0010_0000);
    if (limit_field != 0 && mb4 < limit_field && !hole) return 3'd4;
    return 3'd0;
  endfunction

  task automatic check(input string tag, input logic v, input logic al,
                       input logic [2:0] rs);
    n_run++;
    if (dec_valid !== v || dec_alloc !== al || dec_reason !== rs) begin
      n_fail++;
      $display("FAIL %s: got v=%0b a=%0b r=%0d exp v=%0b a=%0b r=%0d",
               tag, dec_valid, dec_alloc, dec_reason, v, al, rs);
    end
  endtask

  task automatic clear_conds();
    cache_dis = 0; page_cd = 0; cache_inh = 0; mem_uc = 0; mem_wc = 0;
    sec_tag_hit = 0; sec_line_valid = 0; fill_done = 0;
  endtask

  // Drive one cycle at negedge, optional write and fill, check next negedge.
  task automatic step(input string tag, input bit req, input logic [31:0] a,
                      input bit fd, input logic [19:0] fp);
    logic [2:0] r;
    wr_req = req; wr_addr = a; fill_done = fd; fill_page = fp;
    r = exp_reason(a);
    @(negedge clk);
    if (fd && !cache_dis && !cache_inh) begin m_vld = 1'b1; m_page = fp; end
    if (req) check(tag, 1'b1, (r >= 3'd2), r);
    else     check(tag, 1'b0, 1'b0, 3'd0);
    wr_req = 0;
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not end, exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [19:0] pool [4];
    void'($urandom(32'd7345));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", 1'b0, 1'b0, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    limit_field = 7'd0;
    // R12: no page hit before any fill; R7 limit 0 gives nothing
    step("R12 no page before fill", 1, 32'h0000_1000, 0, 20'h0);
    step("R10 idle cycle", 0, 32'h0, 0, 20'h0);
    // R7 below limit
    limit_field = 7'd2;
    step("R7 below limit", 1, 32'h0070_0000, 0, 20'h0);
    step("R7 at limit edge", 1, 32'h0080_0000, 0, 20'h0);
    // R8 hole borders
    step("R8 hole low", 1, 32'h000A_0000, 0, 20'h0);
    step("R8 hole high", 1, 32'h000F_FFFF, 0, 20'h0);
    step("R8 below hole", 1, 32'h0009_FFFF, 0, 20'h0);
    step("R8 above hole", 1, 32'h0010_0000, 0, 20'h0);
    // R6 sector override in hole (R9)
    sec_tag_hit = 1;
    step("R9 sector in hole", 1, 32'h000B_0040, 0, 20'h0);
    sec_line_valid = 1;
    step("R6 valid line no alloc", 1, 32'h0500_0000, 0, 20'h0);
    clear_conds();
    // R11 fill loads; same-cycle write sees old value
    step("R11 same-cycle write", 1, 32'h000C_0000, 1, 20'h000C0);
    step("R5 page hit in hole", 1, 32'h000C_0FF0, 0, 20'h0);
    // R11 suppressed fill under cache_dis
    cache_dis = 1;
    step("R1 blocked", 1, 32'h000C_0000, 1, 20'h12345);
    cache_dis = 0;
    step("R11 suppressed fill", 1, 32'h000C_0000, 0, 20'h0);
    cache_inh = 1;
    step("R3 blocked", 1, 32'h000C_0000, 1, 20'h54321);
    cache_inh = 0;
    page_cd = 1;
    step("R2 blocked", 1, 32'h000C_0000, 0, 20'h0);
    page_cd = 0; mem_wc = 1;
    step("R4 wc blocked", 1, 32'h000C_0000, 0, 20'h0);
    mem_wc = 0; mem_uc = 1; sec_tag_hit = 1;
    step("R4 uc blocked", 1, 32'h0000_0000, 0, 20'h0);
    mem_uc = 0;
    step("R9 page beats sector", 1, 32'h000C_0000, 0, 20'h0);
    clear_conds();
    limit_field = 7'd127;
    step("R7 max limit", 1, 32'h1F00_0000, 0, 20'h0);
    step("R7 above max limit", 1, 32'h2000_0000, 0, 20'h0);

    // Random phase
    pool[0] = 20'h000A0; pool[1] = 20'h00100; pool[2] = 20'h00009; pool[3] = 20'h00800;
    for (int i = 0; i < 4000; i++) begin
      int sel;
      cache_dis      = ($urandom_range(0, 15) == 0);
      page_cd        = ($urandom_range(0, 15) == 0);
      cache_inh      = ($urandom_range(0, 15) == 0);
      mem_uc         = ($urandom_range(0, 15) == 0);
      mem_wc         = ($urandom_range(0, 15) == 0);
      sec_tag_hit    = ($urandom_range(0, 3) == 0);
      sec_line_valid = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) limit_field = 7'($urandom_range(0, 127));
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 32'h000A_0000 + 32'($urandom_range(0, 32'h5FFFF));
        1: a = {pool[$urandom_range(0, 3)], 12'($urandom_range(0, 4095))};
        2: a = 32'($urandom_range(0, 32'h01FF_FFFF));
        3: a = (m_vld ? {m_page, 12'h0} : 32'h0) + 32'($urandom_range(0, 4095));
        4: a = ($urandom_range(0, 1) ? 32'h000A_0000 : 32'h0010_0000)
               - 32'($urandom_range(0, 1));
        default: a = $urandom;
      endcase
      step("R10 random", $urandom_range(0, 3) != 0, a,
           $urandom_range(0, 4) == 0, pool[$urandom_range(0, 3)]);
    end
    clear_conds();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule